// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block sits between a set of peripheral DMA request lines and the channel engines of a DMA controller. Each request input owns a small map register that says whether the request is routed at all and, if so, to which channel. The block merges every routed request into a per-channel request level. It watches each channel level for edges and raises two status indications toward the channel: a sticky flag when a request appears, and a one-cycle pulse when a request goes away.

Software reaches the map registers through a 32-bit word register bus. The registers are split across two address windows: a large window for the first 64 requests and a short one for the rest. A write that enables a mapping to a channel the controller does not have is refused and flagged on an error output. Three legacy request-status words stay in the address map. They read as zero and ignore writes.

Top module: `req_chan_mapper`

## Requirements
- R1: After reset every map entry reads zero, every channel request is low, and the start flag, end pulse and bus error outputs are low.
- R2: A map entry holds a valid flag in bit 7 and a channel number in bits 4:0. Reads return only those bits, and every other data bit reads zero.
- R3: Map entry n for n below 64 sits at byte address 0x100 + 4n. Entry n for n from 64 to 74 sits at 0x1100 + 4(n-64). Any other address reads zero.
- R4: The words at 0xE0, 0xE4 and 0xE8 always read zero, and writing them changes no map entry.
- R5: A request whose map entry has the valid flag clear drives no channel.
- R6: `ch_req_o[c]` goes high one clock after any valid entry targeting channel c sees its request high. It goes low one clock after none does. Remapping takes effect in the same way.
- R7: When a channel request rises, that channel's start flag is set in the same cycle, and it stays set while the request stays high.
- R8: When a channel request falls, that channel's end pulse is high for exactly one cycle, and the start flag clears at the same time.
- R9: Requests mapped to the same channel are ORed. Dropping one of them while another is still high produces no edge, no pulse and no flag change.
- R10: A write with bit 7 set and a channel number at or above NUM_CH leaves the entry unchanged and raises `bus_err_o` for one cycle. The same number written with bit 7 clear is stored without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 16 | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational during a read |
| bus_err_o | output | 1 | One-cycle pulse for a refused map write |
| req_i | input | NUM_REQ | Peripheral request levels |
| ch_req_o | output | NUM_CH | Merged request level per channel |
| ch_start_o | output | NUM_CH | Sticky request-appeared flag per channel |
| ch_end_o | output | NUM_CH | One-cycle request-ended pulse per channel |

## Verification
The bench targets the window edges: the first and last entry of each window, and the word just past the short window. A decoder with an off-by-one boundary would alias or lose an entry there. It writes channel numbers exactly at and above the channel count, with the valid flag both set and clear, to catch a comparison that is strict where it should not be or that ignores the valid flag. With two requests on one channel it drops one of them, which exposes routing that pulses per input instead of per channel. It also remaps a live request to another channel, so a design that tracks edges per input rather than per channel level misses the pulse on the old channel.

// File: rtl/req_map_pkg.sv
package req_map_pkg;
  localparam int unsigned CHN_W    = 5;
  localparam int unsigned VLD_BIT  = 7;
  localparam int unsigned BUS_AW   = 16;
  localparam int unsigned BUS_DW   = 32;
  localparam int unsigned LO_SPAN  = 64;

  typedef struct packed {
    logic             vld;
    logic [CHN_W-1:0] chn;
  } map_ent_t;
endpackage

// File: rtl/req_map_dec.sv
module req_map_dec
  import req_map_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned IDX_W   = $clog2(NUM_REQ)
) (
  input  logic [BUS_AW-1:0] addr_i,
  output logic              map_hit_o,
  output logic [IDX_W-1:0]  map_idx_o,
  output logic              stat_hit_o
);
  localparam int unsigned LO_N = (NUM_REQ < LO_SPAN) ? NUM_REQ : LO_SPAN;
  localparam int unsigned HI_N = (NUM_REQ > LO_SPAN) ? NUM_REQ - LO_SPAN : 0;

  logic [5:0] word;
  logic       aligned, lo_hit, hi_hit;

  always_comb begin
    word       = addr_i[7:2];
    aligned    = (addr_i[1:0] == 2'b00);
    lo_hit     = aligned && (addr_i[15:8] == 8'h01) && (32'(word) < LO_N);
    hi_hit     = aligned && (addr_i[15:8] == 8'h11) && (32'(word) < HI_N);
    stat_hit_o = aligned && (addr_i[15:4] == 12'h00E) && (addr_i[3:2] != 2'b11);
    map_hit_o  = lo_hit || hi_hit;
    map_idx_o  = hi_hit ? IDX_W'(32'(word) + LO_SPAN) : IDX_W'(word);
  end
endmodule

// File: rtl/req_map_regs.sv
module req_map_regs
  import req_map_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned IDX_W   = $clog2(NUM_REQ)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [BUS_DW-1:0]        wdata_i,
  output map_ent_t [NUM_REQ-1:0]   map_o,
  output logic                     err_o
);
  map_ent_t [NUM_REQ-1:0] map_q;
  map_ent_t               new_ent;
  logic                   bad;
  logic                   err_q;

  always_comb begin
    new_ent.vld = wdata_i[VLD_BIT];
    new_ent.chn = wdata_i[CHN_W-1:0];
    bad         = new_ent.vld && (32'(new_ent.chn) >= NUM_CH);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_i && bad;
      if (wr_i && !bad) map_q[idx_i] <= new_ent;
    end
  end

  assign map_o = map_q;
  assign err_o = err_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[BUS_DW-1:VLD_BIT+1], wdata_i[VLD_BIT-1:CHN_W]};

  a_r10_reject_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $stable(map_q));

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
    a_r10_no_bad_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
      map_q[i].vld |-> (32'(map_q[i].chn) < NUM_CH));
  end
endmodule

// File: rtl/req_map_route.sv
module req_map_route
  import req_map_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned NUM_CH  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_REQ-1:0]     req_i,
  input  map_ent_t [NUM_REQ-1:0] map_i,
  output logic [NUM_CH-1:0]      ch_req_o,
  output logic [NUM_CH-1:0]      start_o,
  output logic [NUM_CH-1:0]      end_o
);
  logic [NUM_CH-1:0] lvl_d, lvl_q, start_q, end_q, rise, fall;

  always_comb begin
    lvl_d = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (req_i[r] && map_i[r].vld && (32'(map_i[r].chn) == c)) lvl_d[c] = 1'b1;
      end
    end
    rise = lvl_d & ~lvl_q;
    fall = lvl_q & ~lvl_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
    end else begin
      lvl_q   <= lvl_d;
      start_q <= (start_q | rise) & ~fall;
      end_q   <= fall;
    end
  end

  assign ch_req_o = lvl_q;
  assign start_o  = start_q;
  assign end_o    = end_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r7_rise_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lvl_q[c]) |-> start_q[c]);
    a_r7_flag_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_q[c] |-> lvl_q[c]);
    a_r8_fall_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(lvl_q[c]) |-> (end_q[c] && !start_q[c]));
    a_r8_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      end_q[c] |=> !end_q[c]);
  end
endmodule

// File: rtl/req_chan_mapper.sv
module req_chan_mapper
  import req_map_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned NUM_CH  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_en_i,
  input  logic               bus_we_i,
  input  logic [15:0]        bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               bus_err_o,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_CH-1:0]  ch_req_o,
  output logic [NUM_CH-1:0]  ch_start_o,
  output logic [NUM_CH-1:0]  ch_end_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REQ);

  logic                   map_hit, stat_hit;
  logic [IDX_W-1:0]       map_idx;
  map_ent_t [NUM_REQ-1:0] map;
  map_ent_t               rd_ent;

  req_map_dec #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_dec (
    .addr_i     (bus_addr_i),
    .map_hit_o  (map_hit),
    .map_idx_o  (map_idx),
    .stat_hit_o (stat_hit)
  );

  req_map_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_en_i && bus_we_i && map_hit),
    .idx_i   (map_idx),
    .wdata_i (bus_wdata_i),
    .map_o   (map),
    .err_o   (bus_err_o)
  );

  req_map_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .map_i    (map),
    .ch_req_o (ch_req_o),
    .start_o  (ch_start_o),
    .end_o    (ch_end_o)
  );

  // status words fall through to zero: no hit on the map decode
  always_comb begin
    rd_ent      = map_hit ? map[map_idx] : '0;
    bus_rdata_o = '0;
    if (bus_en_i && !bus_we_i) begin
      bus_rdata_o[VLD_BIT]     = rd_ent.vld;
      bus_rdata_o[CHN_W-1:0]   = rd_ent.chn;
    end
  end

  a_r3_one_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({map_hit, stat_hit}));
  a_r4_stat_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && !bus_we_i && stat_hit) |-> (bus_rdata_o == 32'h0));
  a_r2_read_fields_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rdata_o & 32'hFFFF_FF60) == 32'h0);
endmodule

// File: tb/req_chan_mapper_tb.sv
`timescale 1ns/1ps
module req_chan_mapper_tb;
  localparam int NUM_REQ = 75;
  localparam int NUM_CH  = 16;
  localparam real CLK_PERIOD = 5.0;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               bus_en = 1'b0, bus_we = 1'b0;
  logic [15:0]        bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic               bus_err;
  logic [NUM_REQ-1:0] req = '0;
  logic [NUM_CH-1:0]  ch_req, ch_start, ch_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  req_chan_mapper #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_err_o(bus_err), .req_i(req), .ch_req_o(ch_req),
    .ch_start_o(ch_start), .ch_end_o(ch_end)
  );

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model
  logic              m_vld [NUM_REQ];
  logic [4:0]        m_chn [NUM_REQ];
  logic [NUM_CH-1:0] m_lvl = '0, m_start = '0, m_end = '0;
  logic              m_err = 1'b0;

  function automatic int addr_to_idx(logic [15:0] a);
    if (a[1:0] != 2'b00) return -1;
    if (a >= 16'h0100 && a <= 16'h01FC) return int'(a - 16'h0100) / 4;
    if (a >= 16'h1100 && a <= 16'h1128) return 64 + int'(a - 16'h1100) / 4;
    return -1;
  endfunction

  function automatic logic [NUM_CH-1:0] calc_lvl();
    logic [NUM_CH-1:0] v = '0;
    for (int r = 0; r < NUM_REQ; r++)
      if (req[r] && m_vld[r] && int'(m_chn[r]) < NUM_CH) v[m_chn[r]] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] pick(int sel);
    case (sel)
      0: return bus_rdata;
      1: return 32'(ch_req);
      2: return 32'(ch_start);
      3: return 32'(ch_end);
      default: return 32'(bus_err);
    endcase
  endfunction

  task automatic push(int sel, logic [31:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = pick(it.sel);
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s act=%08h exp=%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    logic [NUM_CH-1:0] nl;
    int idx;
    @(posedge clk);
    nl      = calc_lvl();
    m_start = (m_start | (nl & ~m_lvl)) & ~(m_lvl & ~nl);
    m_end   = m_lvl & ~nl;
    m_lvl   = nl;
    m_err   = 1'b0;
    if (bus_en && bus_we) begin
      idx = addr_to_idx(bus_addr);
      if (idx >= 0) begin
        if (bus_wdata[7] && int'(bus_wdata[4:0]) >= NUM_CH) m_err = 1'b1;
        else begin
          m_vld[idx] = bus_wdata[7];
          m_chn[idx] = bus_wdata[4:0];
        end
      end
    end
    #1;
    push(1, 32'(m_lvl),   "R6 channel request");
    push(2, 32'(m_start), "R7 start flag");
    push(3, 32'(m_end),   "R8 end pulse");
    push(4, 32'(m_err),   "R10 bus error");
  endtask

  task automatic bus_write(logic [15:0] a, logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, logic [31:0] exp, string tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    push(0, exp, tag);
    @(negedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic set_req(int r, logic v);
    req[r] = v;
    tick();
  endtask

  initial begin
    for (int r = 0; r < NUM_REQ; r++) begin m_vld[r] = 1'b0; m_chn[r] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    push(1, 0, "R1 reset ch_req"); push(2, 0, "R1 reset start");
    push(3, 0, "R1 reset end");    push(4, 0, "R1 reset err");
    bus_read(16'h0100, 0, "R1 reset map0");
    bus_read(16'h1128, 0, "R1 reset map74");

    // R2 field format
    bus_write(16'h010C, 32'h0000_0085);
    bus_read(16'h010C, 32'h85, "R2 map3 readback");
    bus_write(16'h0110, 32'hFFFF_FFE3);
    bus_read(16'h0110, 32'h83, "R2 junk bits masked");

    // R3 windows
    bus_write(16'h1100, 32'h85);
    bus_read(16'h1100, 32'h85, "R3 map64 readback");
    bus_read(16'h0100, 32'h0, "R3 map0 not aliased");
    bus_write(16'h1128, 32'h8F);
    bus_read(16'h1128, 32'h8F, "R3 map74 readback");
    bus_read(16'h112C, 32'h0, "R3 past short window");
    bus_read(16'h01FC, 32'h0, "R3 map63 untouched");
    bus_write(16'h01FC, 32'h81);
    bus_read(16'h01FC, 32'h81, "R3 map63 readback");
    bus_read(16'h010E, 32'h0, "R3 misaligned reads zero");

    // R4 status words
    bus_write(16'h00E0, 32'hFFFF_FFFF);
    bus_write(16'h00E4, 32'hFFFF_FFFF);
    bus_write(16'h00E8, 32'hFFFF_FFFF);
    bus_read(16'h00E0, 32'h0, "R4 status0 zero");
    bus_read(16'h00E4, 32'h0, "R4 status1 zero");
    bus_read(16'h00E8, 32'h0, "R4 status2 zero");
    bus_read(16'h010C, 32'h85, "R4 map3 unchanged");

    // R5 invalid entries ignored
    bus_write(16'h012C, 32'h05);
    set_req(10, 1'b1);
    set_req(11, 1'b1);
    tick();
    set_req(10, 1'b0);
    set_req(11, 1'b0);

    // R6 R7 R8 single request
    set_req(3, 1'b1);
    repeat (3) tick();
    set_req(3, 1'b0);
    repeat (2) tick();

    // R9 two requests on one channel
    set_req(3, 1'b1);
    set_req(64, 1'b1);
    set_req(3, 1'b0);
    tick();
    set_req(64, 1'b0);
    tick();

    // opposite phases on two channels
    set_req(4, 1'b1);
    req[74] = 1'b1; req[4] = 1'b0; tick();
    req[74] = 1'b0; req[4] = 1'b1; tick();
    req[4] = 1'b0; tick();
    tick();

    // R6 remap a live request
    set_req(3, 1'b1);
    tick();
    bus_write(16'h010C, 32'h87);
    tick();
    bus_read(16'h010C, 32'h87, "R6 remap readback");
    set_req(3, 1'b0);
    tick();

    // R10 channel bound
    bus_write(16'h0114, 32'h94);
    bus_read(16'h0114, 32'h0, "R10 chan 20 refused");
    bus_write(16'h0114, 32'h90);
    bus_read(16'h0114, 32'h0, "R10 chan 16 refused");
    bus_write(16'h0114, 32'h8F);
    bus_read(16'h0114, 32'h8F, "R10 chan 15 accepted");
    bus_write(16'h0114, 32'h14);
    bus_read(16'h0114, 32'h14, "R10 invalid chan 20 stored");
    set_req(5, 1'b1);
    tick();
    set_req(5, 1'b0);
    tick();

    @(negedge clk); #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=%08h exp=%08h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule